// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a single-clock synchronous SRAM core. Reads and writes can follow each other in any order, every cycle, with no idle cycle at a change of direction. Every synchronous input is captured on the rising clock edge: address, load/advance, write, lane write enables, the three selects and the clock enable. A command goes through a two-register pipeline. A read returns its word on `rdata` two active edges after it was captured. A write takes its data from `wdata` at the same point in the pipeline, so both directions share one timing.

A load cycle starts an access at the given address. Advance cycles then step a two-bit burst counter, which gives four beats per burst. The burst order is fixed by a strap and is either linear (a modulo-4 increment of the low address bits) or interleaved (the low bits XORed with the beat count). Two more inputs act without the clock:

- The output enable forces `rdata` to zero.
- The sleep input blocks every access and keeps the stored contents.

Top module: `zbt_sram`

## Requirements
- R1: A synchronous reset clears the pipeline, the burst state and the read register, so `rdata` reads zero when `out_en` is 1. The array contents are not reset.
- R2: A read captured on active edge k drives the stored word on `rdata` after active edge k+2 and holds it until the next read completes.
- R3: A write captured on active edge k stores the `wdata` present at active edge k+2. Reads and writes may alternate every cycle, and a read always sees every write captured before it.
- R4: Lane i covers `wdata[9i+8:9i]`. It is written only if `lane_wr[i]` is 1 in the write beat's cycle, and the other lanes keep their contents.
- R5: With `burst_next`=1 after a load, each beat adds 1 to the beat count. In linear order (`order_il`=0) the low two address bits are the start plus the count, modulo 4. The upper bits and the read/write type of the load are kept, and `wr` is ignored.
- R6: In interleaved order (`order_il`=1) the low two address bits of a beat are the start bits XOR the beat count.
- R7: A load starts an access only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Otherwise the cycle is a deselect: nothing is written, `rdata` holds, and later advance cycles are ignored until the next valid load.
- R8: While `clk_en`=0 no register advances: no command, burst step, write or read takes effect.
- R9: `out_en`=0 forces `rdata` to all zeros at once, with no clock edge. `out_en`=1 shows the read register at once.
- R10: While `sleep`=1 no new access is issued and no pending access executes. Stored contents are kept, and the burst state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; 0 freezes all state |
| sel0_n | input | 1 | Select, active low |
| sel1 | input | 1 | Select, active high |
| sel2_n | input | 1 | Select, active low |
| burst_next | input | 1 | 1 = advance burst, 0 = load new address |
| wr | input | 1 | 1 = write, 0 = read (sampled on load) |
| lane_wr | input | 8 | Per-lane write enables |
| addr | input | 6 | Word address |
| wdata | input | 72 | Write data, eight 9-bit lanes |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| sleep | input | 1 | Asynchronous access block |
| out_en | input | 1 | Asynchronous output enable |
| rdata | output | 72 | Read data |

## Verification
The assertions assume the following about the inputs:
- The reset is held for at least one edge before any access.
- `order_il` changes only while no burst is in progress.
- `sleep`, `out_en` and the selects are steady around each rising edge, so each edge sees one level.

The stimulus follows these rules. It changes every input at the falling edge. It moves the order strap only after deselect cycles have emptied the pipeline. It reads only addresses and lanes that were written earlier, so every expected word is defined.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    localparam int ADDR_W  = 6;
    localparam int LANES   = 8;
    localparam int LANE_W  = 9;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BEAT_W  = 2;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  lanes;
    } access_t;

    // Low address bits of a burst beat, given start bits and beat count.
    function automatic logic [BEAT_W-1:0] beat_low(
        input burst_order_e      ord,
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] count
    );
        if (ord == ORDER_INTERLEAVED)
            return start ^ count;
        return start + count;
    endfunction

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
    import zbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              burst_next,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [ADDR_W-1:0] addr,
    input  burst_order_e      order,
    output access_t           cmd_q
);

    logic              on_q,   on_d;
    logic              kind_q, kind_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [BEAT_W-1:0] cnt_q,  cnt_d;
    access_t           cmd_d;
    logic              sel_ok;

    assign sel_ok = !sel0_n && sel1 && !sel2_n;

    always_comb begin
        on_d   = on_q;
        kind_d = kind_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        cmd_d  = '0;
        if (!sleep) begin
            if (!burst_next) begin
                if (sel_ok) begin
                    on_d        = 1'b1;
                    kind_d      = wr;
                    base_d      = addr;
                    cnt_d       = '0;
                    cmd_d.valid = 1'b1;
                    cmd_d.write = wr;
                    cmd_d.addr  = addr;
                    cmd_d.lanes = lane_wr;
                end else begin
                    on_d = 1'b0;
                end
            end else if (on_q) begin
                cnt_d       = cnt_q + 1'b1;
                cmd_d.valid = 1'b1;
                cmd_d.write = kind_q;
                cmd_d.addr  = {base_q[ADDR_W-1:BEAT_W],
                               beat_low(order, base_q[BEAT_W-1:0], cnt_d)};
                cmd_d.lanes = lane_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_q   <= 1'b0;
            kind_q <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            cmd_q  <= '0;
        end else if (clk_en) begin
            on_q   <= on_d;
            kind_q <= kind_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            cmd_q  <= cmd_d;
        end
    end

    // R5: an accepted advance steps the beat counter by one
    a_r5_beat_step: assert property (@(posedge clk) disable iff (rst)
        (clk_en && burst_next && on_q && !sleep) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R7: a load with any select inactive issues nothing
    a_r7_deselect: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !burst_next && !sleep && (sel0_n || !sel1 || sel2_n)) |=> !cmd_q.valid);

    // R10: nothing is issued while sleep is high
    a_r10_no_issue: assert property (@(posedge clk) disable iff (rst)
        (clk_en && sleep) |=> !cmd_q.valid);

endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int STAGES = 1
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    clk_en,
    input  access_t d,
    output access_t q
);

    access_t chain [STAGES+1];

    assign chain[0] = d;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        access_t r;
        always_ff @(posedge clk) begin
            if (rst)
                r <= '0;
            else if (clk_en)
                r <= chain[s];
        end
        assign chain[s+1] = r;
    end

    assign q = chain[STAGES];

endmodule

// File: rtl/zbt_array.sv
module zbt_array
    import zbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sleep,
    input  access_t           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);

    logic fire;

    assign fire = clk_en && op.valid && !sleep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (fire && op.write && op.lanes[g])
                bank[op.addr] <= wdata[g*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                rd_q <= '0;
            else if (fire && !op.write)
                rd_q <= bank[op.addr];
        end

        assign rdata_q[g*LANE_W +: LANE_W] = rd_q;
    end

    // R1: read register is clear on the first edge after reset
    a_r1_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata_q == '0));

    // R8: frozen clock enable keeps the read register
    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(rdata_q));

    // R10: sleep blocks the pending read
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        sleep |=> $stable(rdata_q));

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              burst_next,
    input  logic              wr,
    input  logic [LANES-1:0]  lane_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              order_il,
    input  logic              sleep,
    input  logic              out_en,
    output logic [DATA_W-1:0] rdata
);

    localparam int ALIGN_STAGES = 1;

    access_t           issued;
    access_t           exec_op;
    logic [DATA_W-1:0] rd_word;

    zbt_issue u_issue (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .sleep      (sleep),
        .sel0_n     (sel0_n),
        .sel1       (sel1),
        .sel2_n     (sel2_n),
        .burst_next (burst_next),
        .wr         (wr),
        .lane_wr    (lane_wr),
        .addr       (addr),
        .order      (burst_order_e'(order_il)),
        .cmd_q      (issued)
    );

    zbt_pipe #(.STAGES(ALIGN_STAGES)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .clk_en (clk_en),
        .d      (issued),
        .q      (exec_op)
    );

    zbt_array u_array (
        .clk     (clk),
        .rst     (rst),
        .clk_en  (clk_en),
        .sleep   (sleep),
        .op      (exec_op),
        .wdata   (wdata),
        .rdata_q (rd_word)
    );

    assign rdata = out_en ? rd_word : '0;

endmodule

// File: tb/test_zbt_sram.sv
`timescale 1ns/1ps
module test_zbt_sram;
    import zbt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clk_en = 1'b1;
    logic              sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic              burst_next = 1'b0, wr = 1'b0;
    logic [LANES-1:0]  lane_wr = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              order_il = 1'b0, sleep = 1'b0, out_en = 1'b1;
    logic [DATA_W-1:0] rdata;

    int n_chk = 0, n_bad = 0, seq = 0;

    always #10 clk = ~clk;

    zbt_sram i_zbt_sram (
        .clk(clk), .rst(rst), .clk_en(clk_en), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .burst_next(burst_next), .wr(wr), .lane_wr(lane_wr),
        .addr(addr), .wdata(wdata), .order_il(order_il), .sleep(sleep),
        .out_en(out_en), .rdata(rdata)
    );

    // Stimulus rows: {burst_next, wr, selected, addr[5:0], lane_wr[7:0]}
    localparam int NV = 22;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 6'd4,  8'hFF},  // write burst 4..7 (R5 linear)
        {1'b1, 1'b1, 1'b1, 6'd0,  8'hFF},
        {1'b1, 1'b0, 1'b1, 6'd0,  8'hFF},  // wr ignored on advance (R5)
        {1'b1, 1'b1, 1'b1, 6'd0,  8'hFF},
        {1'b0, 1'b0, 1'b1, 6'd5,  8'h00},  // read 5, 6 (R2)
        {1'b1, 1'b0, 1'b1, 6'd0,  8'h00},
        {1'b0, 1'b1, 1'b1, 6'd4,  8'h0F},  // low lanes only (R4)
        {1'b0, 1'b0, 1'b1, 6'd4,  8'h00},  // read right after write (R3)
        {1'b0, 1'b1, 1'b1, 6'd5,  8'hF0},  // high lanes only (R4)
        {1'b0, 1'b0, 1'b1, 6'd5,  8'h00},
        {1'b1, 1'b0, 1'b1, 6'd0,  8'h00},
        {1'b0, 1'b1, 1'b0, 6'd7,  8'hFF},  // deselected write (R7)
        {1'b1, 1'b1, 1'b1, 6'd0,  8'hFF},  // advance after deselect ignored (R7)
        {1'b0, 1'b0, 1'b1, 6'd7,  8'h00},
        {1'b0, 1'b0, 1'b0, 6'd0,  8'h00},
        {1'b0, 1'b0, 1'b0, 6'd0,  8'h00},
        {1'b0, 1'b0, 1'b1, 6'd6,  8'h00},  // linear wrap 6,7,4,5 (R5)
        {1'b1, 1'b0, 1'b1, 6'd0,  8'h00},
        {1'b1, 1'b0, 1'b1, 6'd0,  8'h00},
        {1'b1, 1'b0, 1'b1, 6'd0,  8'h00},
        {1'b0, 1'b0, 1'b0, 6'd0,  8'h00},
        {1'b0, 1'b0, 1'b0, 6'd0,  8'h00}
    };

    // Reference model built from the requirements
    logic [DATA_W-1:0] m_mem [DEPTH];
    logic              m_av = 0, m_aw = 0, m_bv = 0, m_bw = 0, m_on = 0, m_kind = 0;
    logic [ADDR_W-1:0] m_aa = '0, m_ba = '0, m_base = '0;
    logic [LANES-1:0]  m_al = '0, m_bl = '0;
    logic [1:0]        m_cnt = '0;
    logic [DATA_W-1:0] m_q = '0;

    function automatic logic [DATA_W-1:0] pat(input int i);
        logic [7:0] b;
        b = 8'(i * 29 + 7);
        return {b, b, b, b, b, b, b, b, b};
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_av = 0; m_bv = 0; m_on = 0; m_cnt = '0; m_q = '0;
        end else if (clk_en) begin
            if (m_bv && !sleep) begin
                if (m_bw) begin
                    for (int g = 0; g < LANES; g++)
                        if (m_bl[g]) m_mem[m_ba][g*LANE_W +: LANE_W] = wdata[g*LANE_W +: LANE_W];
                end else begin
                    m_q = m_mem[m_ba];
                end
            end
            m_bv = m_av; m_bw = m_aw; m_ba = m_aa; m_bl = m_al;
            m_av = 0;
            if (!sleep) begin
                if (!burst_next) begin
                    if (!sel0_n && sel1 && !sel2_n) begin
                        m_av = 1; m_aw = wr; m_aa = addr; m_al = lane_wr;
                        m_on = 1; m_kind = wr; m_base = addr; m_cnt = '0;
                    end else begin
                        m_on = 0;
                    end
                end else if (m_on) begin
                    m_cnt = m_cnt + 2'd1;
                    m_av = 1; m_aw = m_kind; m_al = lane_wr;
                    m_aa = {m_base[ADDR_W-1:2],
                            order_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt)};
                end
            end
        end
    endtask

    task automatic check(input string tag);
        logic [DATA_W-1:0] exp;
        exp = out_en ? m_q : '0;
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: rdata=%h expected %h", tag, rdata, exp);
        end
    endtask

    task automatic step(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic go(input logic nx, input logic w, input logic s0n, input logic s1,
                      input logic s2n, input logic [ADDR_W-1:0] a,
                      input logic [LANES-1:0] l, input string tag);
        burst_next = nx; wr = w; sel0_n = s0n; sel1 = s1; sel2_n = s2n;
        addr = a; lane_wr = l; wdata = pat(seq); seq++;
        step(tag);
    endtask

    task automatic idle(input string tag);
        go(0, 0, 1, 0, 1, '0, '0, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 1'b0;

        // Table walk: R2, R3, R4, R5, R7 (linear order)
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            v = VEC[i];
            go(v[16], v[15], ~v[14], v[14], ~v[14], v[13:8], v[7:0], "R3");
        end

        // R9: output enable acts without a clock edge
        out_en = 1'b0; #1; check("R9");
        out_en = 1'b1; #1; check("R9");

        // R6: interleaved burst from start 13 (low bits 01)
        order_il = 1'b1;
        go(0, 1, 0, 1, 0, 6'd13, 8'hFF, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'hFF, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'hFF, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'hFF, "R6");
        idle("R6"); idle("R6");
        for (int a = 12; a < 16; a++) go(0, 0, 0, 1, 0, 6'(a), 8'h00, "R6");
        go(0, 0, 0, 1, 0, 6'd12, 8'h00, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'h00, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'h00, "R6");
        go(1, 0, 0, 1, 0, 6'd0,  8'h00, "R6");
        idle("R6"); idle("R6");
        order_il = 1'b0;

        // R7: each select inactive in turn blocks a write
        go(0, 1, 0, 1, 0, 6'd20, 8'hFF, "R7");
        idle("R7"); idle("R7");
        go(0, 1, 1, 1, 0, 6'd20, 8'hFF, "R7");
        go(0, 1, 0, 0, 0, 6'd20, 8'hFF, "R7");
        go(0, 1, 0, 1, 1, 6'd20, 8'hFF, "R7");
        idle("R7"); idle("R7");
        go(0, 0, 0, 1, 0, 6'd20, 8'h00, "R7");
        idle("R7"); idle("R7");

        // R8: clock enable low freezes a pending write and the read register
        go(0, 1, 0, 1, 0, 6'd21, 8'hFF, "R8");
        clk_en = 1'b0;
        go(0, 0, 0, 1, 0, 6'd20, 8'h00, "R8");
        go(0, 0, 0, 1, 0, 6'd20, 8'h00, "R8");
        go(0, 0, 0, 1, 0, 6'd20, 8'h00, "R8");
        clk_en = 1'b1;
        idle("R8"); idle("R8");
        go(0, 0, 0, 1, 0, 6'd21, 8'h00, "R8");
        idle("R8"); idle("R8");

        // R10: sleep blocks a write and a pending read, contents kept
        sleep = 1'b1;
        go(0, 1, 0, 1, 0, 6'd20, 8'hFF, "R10");
        idle("R10"); idle("R10");
        sleep = 1'b0;
        go(0, 0, 0, 1, 0, 6'd20, 8'h00, "R10");
        idle("R10"); idle("R10");
        go(0, 0, 0, 1, 0, 6'd21, 8'h00, "R10");
        sleep = 1'b1;
        idle("R10"); idle("R10");
        sleep = 1'b0;
        idle("R10");
        go(0, 0, 0, 1, 0, 6'd21, 8'h00, "R10");
        idle("R10"); idle("R10");

        finish_run();
    end

endmodule